// File: doc/BRIEF.md
# Synchronous Burst SRAM

A single-clock static memory of 2^ADDR_W words, each BYTES bytes of BYTE_W bits (by default 1024 words of 36 bits in four 9-bit bytes). Addresses, write data, chip enables, load strobes, the advance input and the write controls are all captured on the rising clock edge. Either of two active-low load strobes starts an access. A strobe captures the external address into a burst register and clears a 2-bit beat counter. A new address can be taken on every cycle. While a burst is running, an active-low advance input steps the counter, and the counter supplies the two low address bits of each beat. Those bits follow linear order or interleaved order, chosen by a strap input.

A second strap selects the read timing. In flow-through mode the array output goes straight to the data port. In pipelined mode it passes through an output register and appears one cycle later. The two modes give 2-1-1-1 and 3-1-1-1 burst reads. A beat is a write when the global write is low, or when the byte-write enable is low with at least one byte select low. The output enable and the sleep input act without the clock. High impedance on the data port is modelled as a low `dout_vld` with `dout` forced to zero.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low and after it rises, no access is in progress and `dout_vld` is 0. Reset acts asynchronously.
- R2: A rising edge with `ld_a_n`=0 or `ld_b_n`=0 and the device selected loads `addr` as the start of a new access. This can happen on consecutive edges, and each loaded word is read without extra cycles.
- R3: With `order_lin`=1, beat k of a burst from start address S reads word {S[hi:2], (S[1:0]+k) mod 4}.
- R4: With `order_lin`=0, beat k reads word {S[hi:2], S[1:0] XOR k}.
- R5: A rising edge with `step_n`=1 and no load leaves the beat unchanged. A rising edge with `step_n`=0 moves to the next beat.
- R6: With `pipe_mode`=0, the word of the current beat is on `dout` in the cycle after the edge that set up that beat.
- R7: With `pipe_mode`=1, the word of a beat appears one cycle later than in R6, so the first word comes two cycles after the load edge.
- R8: With `wr_all_n`=1 and `wr_byte_n`=0, a beat writes `din` byte i (bits i*BYTE_W upward) only where `byte_sel_n[i]`=0, and leaves the other bytes unchanged. With every select at 1 the beat writes nothing.
- R9: With `wr_all_n`=0, a beat writes every byte whatever `wr_byte_n` and `byte_sel_n` hold.
- R10: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A load edge while not selected ends the access: `dout_vld` falls in the next cycle in flow-through mode, and one cycle later in pipelined mode.
- R11: While `out_en_n` is 1, `dout_vld` is 0 at once, with no clock edge needed. Whenever `dout_vld` is 0, `dout` is zero.
- R12: While `sleep` is 1, `dout_vld` is 0 and clock edges change neither the array nor the access state. The access that was open before sleep resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| din | input | BYTES*BYTE_W | Write data |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| ld_a_n | input | 1 | Load strobe A, active low |
| ld_b_n | input | 1 | Load strobe B, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | BYTES | Per-byte write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved (tie low by default) |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through |
| dout | output | BYTES*BYTE_W | Read data, zero when not valid |
| dout_vld | output | 1 | Output driven (low models high impedance) |

## Verification
Some rules are checked by the assertions on every cycle. These are the blanking of the output by the enable and by sleep, the zero data while the output is invalid, the freeze of the burst state during sleep, the capture of the address on a selected load, the hold of the beat when there is no advance, and the drop of the access on a deselecting load. Other behaviour can only be shown by the bench's scenarios: which word each beat returns in both orders, the one-cycle difference between the two read modes, byte-masked and global writes, and the survival of the array contents across sleep. For these the bench fills the whole array and then reads bursts from every start address in all four mode combinations.

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W = 10,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    ld_a_n,
  input  logic                    ld_b_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [BYTES-1:0]        byte_sel_n,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic                    order_lin,
  input  logic                    pipe_mode,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int DW    = BYTES * BYTE_W;
  localparam int WORDS = 1 << ADDR_W;

  logic [DW-1:0]     mem [WORDS];
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              sel_q, pv_q;
  logic [DW-1:0]     pq;

  wire             start = !ld_a_n || !ld_b_n;
  wire             csel  = !cs1_n && cs2 && !cs3_n;
  wire [1:0]       low   = order_lin ? base_q[1:0] + cnt_q : base_q[1:0] ^ cnt_q;
  wire [ADDR_W-1:0] cur  = {base_q[ADDR_W-1:2], low};
  wire [BYTES-1:0] wmask = !wr_all_n ? '1 : (!wr_byte_n ? ~byte_sel_n : '0);
  wire             rd_beat = sel_q && (wmask == '0);
  wire             wr    = sel_q && !sleep && (wmask != '0);
  wire [DW-1:0]    rdata = mem[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      pv_q   <= 1'b0;
      pq     <= '0;
    end else if (!sleep) begin
      if (start) begin
        sel_q <= csel;
        if (csel) begin
          base_q <= addr;
          cnt_q  <= '0;
        end
      end else if (sel_q && !step_n) begin
        cnt_q <= cnt_q + 2'd1;
      end
      pv_q <= rd_beat;
      pq   <= rdata;
    end else begin
      pv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int i = 0; i < BYTES; i++) begin
        if (wmask[i]) mem[cur][i*BYTE_W +: BYTE_W] <= din[i*BYTE_W +: BYTE_W];
      end
    end
  end

  assign dout_vld = !out_en_n && !sleep && (pipe_mode ? pv_q : rd_beat);
  assign dout     = dout_vld ? (pipe_mode ? pq : rdata) : '0;
endmodule

module sync_burst_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DW     = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              csel,
  input logic              sleep,
  input logic              out_en_n,
  input logic              step_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        cnt_q,
  input logic              sel_q,
  input logic              dout_vld,
  input logic [DW-1:0]     dout
);
  AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dout_vld); // R11
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> dout == '0); // R11
  AST_SLEEP_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_vld); // R12
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(base_q) && $stable(cnt_q) && $stable(sel_q)); // R12
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start && csel) |=> sel_q && cnt_q == 2'd0 && base_q == $past(addr)); // R2
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !start && step_n) |=> $stable(cnt_q)); // R5
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start && !csel) |=> !sel_q); // R10
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .DW(BYTES*BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .csel(csel), .sleep(sleep),
  .out_en_n(out_en_n), .step_n(step_n), .addr(addr), .base_q(base_q),
  .cnt_q(cnt_q), .sel_q(sel_q), .dout_vld(dout_vld), .dout(dout)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int AW = 10, NB = 4, BW = 9, DW = NB * BW, WORDS = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs1_n, cs2, cs3_n, ld_a_n, ld_b_n, step_n, wr_all_n, wr_byte_n;
  logic out_en_n, sleep, order_lin, pipe_mode, dout_vld;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic [NB-1:0] byte_sel_n;

  sync_burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .out_en_n(out_en_n), .sleep(sleep), .order_lin(order_lin),
    .pipe_mode(pipe_mode), .dout(dout), .dout_vld(dout_vld));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] model [WORDS];

  function automatic logic [DW-1:0] pat(int a, int s);
    return (DW'(a) * 36'h09E3779B1) ^ DW'(s * 40503) ^ {DW'(a), 4'h0};
  endfunction

  task automatic check(string req, logic ev, logic [DW-1:0] ed);
    n_cmp++;
    if (dout_vld !== ev || dout !== ed) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b data=%h expected vld=%0b data=%h", req, dout_vld, dout, ev, ed);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ld_a_n = 1; ld_b_n = 1; step_n = 1; wr_all_n = 1; wr_byte_n = 1;
    byte_sel_n = '1; cs1_n = 0; cs2 = 1; cs3_n = 0; out_en_n = 0; sleep = 0;
  endtask

  task automatic wr_op(int a, logic [DW-1:0] d, logic gw, logic bw, logic [NB-1:0] bs);
    logic [NB-1:0] m;
    idle(); if (a % 2 == 0) ld_a_n = 0; else ld_b_n = 0;
    addr = AW'(a); tick();
    idle(); wr_all_n = gw; wr_byte_n = bw; byte_sel_n = bs; din = d; tick();
    idle();
    m = !gw ? '1 : (!bw ? ~bs : '0);
    for (int i = 0; i < NB; i++)
      if (m[i]) model[a][i*BW +: BW] = d[i*BW +: BW];
  endtask

  task automatic single_read(int a, string req);
    pipe_mode = 0;
    idle(); ld_a_n = 0; addr = AW'(a); tick();
    idle(); #1 check(req, 1'b1, model[a]);
  endtask

  task automatic burst(int s, logic lin, logic pm);
    int ea;
    string tg;
    tg = $sformatf("%s/%s", lin ? "R3" : "R4", pm ? "R7" : "R6");
    order_lin = lin; pipe_mode = pm;
    idle(); ld_a_n = 0; cs2 = 0; tick();
    idle(); if (s % 2 == 0) ld_a_n = 0; else ld_b_n = 0; addr = AW'(s); tick();
    idle(); step_n = 0;
    for (int k = 0; k <= 4; k++) begin
      #1;
      if (pm) begin
        if (k == 0) check(tg, 1'b0, '0);
        else begin
          ea = {s[AW-1:2], lin ? 2'(s[1:0] + (k - 1)) : 2'(s[1:0] ^ (k - 1))};
          check(tg, 1'b1, model[ea]);
        end
      end else begin
        if (k < 4) begin
          ea = {s[AW-1:2], lin ? 2'(s[1:0] + k) : 2'(s[1:0] ^ k)};
          check(tg, 1'b1, model[ea]);
        end else check("R10 flow deselect", 1'b0, '0);
      end
      if (k == 3) begin ld_a_n = 0; cs2 = 0; end
      if (k < 4) tick();
    end
    idle();
    if (pm) begin tick(); #1 check("R10 pipe deselect", 1'b0, '0); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int a;
    logic [DW-1:0] d;
    rst_n = 0; idle(); addr = '0; din = '0; order_lin = 0; pipe_mode = 0;
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", 1'b0, '0);
    rst_n = 1; tick(); #1 check("R1 after reset", 1'b0, '0);

    for (int i = 0; i < WORDS; i++) wr_op(i, pat(i, 1), 1'b0, 1'b1, '1);

    for (int lin = 0; lin < 2; lin++)
      for (int pm = 0; pm < 2; pm++)
        for (int s = 0; s < WORDS; s++) burst(s, 1'(lin), 1'(pm));

    for (int pm = 0; pm < 2; pm++) begin
      pipe_mode = 1'(pm);
      idle(); ld_a_n = 0; cs2 = 0; tick();
      idle(); ld_a_n = 0; addr = AW'(17);
      for (int i = 0; i < 64; i++) begin
        tick();
        idle();
        if (i % 2 == 0) ld_b_n = 0; else ld_a_n = 0;
        addr = AW'(((i + 1) * 389 + 17) % WORDS);
        #1;
        if (pm == 0) check("R2 flow back-to-back", 1'b1, model[(i * 389 + 17) % WORDS]);
        else if (i > 0) check("R2/R7 pipe back-to-back", 1'b1, model[((i - 1) * 389 + 17) % WORDS]);
      end
      idle();
    end

    pipe_mode = 0; order_lin = 1;
    idle(); ld_a_n = 0; addr = AW'(201); tick();
    idle(); #1 check("R5 beat0", 1'b1, model[201]);
    tick(); #1 check("R5 hold", 1'b1, model[201]);
    step_n = 0; tick(); idle(); #1 check("R5 step", 1'b1, model[202]);

    a = 100;
    wr_op(a, pat(a, 7), 1'b1, 1'b0, 4'b1010);
    single_read(a, "R8 bytes 0 and 2");
    wr_op(a, pat(a, 9), 1'b1, 1'b0, 4'b1111);
    single_read(a, "R8 no select no write");
    wr_op(a, pat(a, 11), 1'b1, 1'b0, 4'b0111);
    single_read(a, "R8 byte 3");
    wr_op(a, pat(a, 13), 1'b0, 1'b0, 4'b1111);
    single_read(a, "R9 global over selects");
    wr_op(a + 1, pat(a, 15), 1'b0, 1'b1, 4'b0000);
    single_read(a + 1, "R9 global");

    single_read(300, "R11 base");
    out_en_n = 1; #1 check("R11 disabled", 1'b0, '0);
    out_en_n = 0; #1 check("R11 re-enabled", 1'b1, model[300]);

    for (int e = 0; e < 3; e++) begin
      single_read(300 + e, "R10 selected");
      idle(); ld_a_n = 0; addr = AW'(5);
      if (e == 0) cs1_n = 1; else if (e == 1) cs2 = 0; else cs3_n = 1;
      tick(); idle(); #1 check("R10 enable off", 1'b0, '0);
    end

    single_read(400, "R12 base");
    sleep = 1; #1 check("R12 asleep", 1'b0, '0);
    wr_all_n = 0; din = ~model[400]; ld_b_n = 0; addr = AW'(7); step_n = 0;
    tick(); tick();
    idle(); #1 check("R12 resume", 1'b1, model[400]);
    single_read(7, "R12 other word intact");
    single_read(400, "R12 contents kept");

    single_read(500, "R1 base");
    rst_n = 0; #1 check("R1 async reset", 1'b0, '0);
    tick(); rst_n = 1; tick(); #1 check("R1 idle after reset", 1'b0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule